// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block performs the shift and rotate step of an integer execution pipe. One request carries an operand, an operand size (byte, word or longword), one of eight operations, a count descriptor and the incoming extend flag. One cycle later the block returns the shifted value together with the extend, negative, zero, overflow and carry flags.

The eight operations are arithmetic, logical, plain rotate and rotate-through-extend, each in both directions. The count can come from three places. It can be taken from a register value modulo 64. It can come from a 3-bit immediate, where the code 0 means eight. For the single-operand memory form it is fixed at one. Every operation accepts every count form.

Only the low byte, word or longword of the operand is shifted. Bits above the selected size pass through unchanged. This lets the result be written straight back to a 32-bit register.

Top module: `shf_unit`

## Requirements
- R1: The operation code `op_sel[2:1]` selects the operation class: 0 arithmetic, 1 logical, 2 plain rotate, 3 rotate through extend. `op_sel[0]` selects the direction: 1 left, 0 right. Arithmetic right replicates the sign bit. Logical shifts fill with zero. Plain rotates feed the outgoing bit back in. Rotate through extend treats X as one extra bit in the loop.
- R2: `size_sel` 0 selects byte, 1 selects word, 2 or 3 selects longword. Result bits above the selected size equal the corresponding operand bits.
- R3: `cnt_mode` 0 uses `cnt_reg` modulo 64 as the count. `cnt_mode` 1 uses `imm_cnt`, where 0 means 8. `cnt_mode` 2 or 3 uses a count of one.
- R4: For a nonzero count, C is the last bit shifted or rotated out. X takes the same value for shifts and for rotate through extend. X keeps `x_in` for plain rotates.
- R5: For arithmetic left, V is 1 when the most significant bit of the sized value changed at any step of the shift. For every other operation V is 0.
- R6: N is the most significant bit of the sized result. Z is 1 when the sized result is zero.
- R7: A count of zero returns the operand unchanged and keeps X equal to `x_in`. It also clears C, except for rotate through extend, where C equals `x_in`.
- R8: Outputs are registered. `out_valid` rises one cycle after `in_valid` and carries that request's result. After reset, `out_valid`, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opnd | input | 32 | Operand value |
| size_sel | input | 2 | Operand size code |
| op_sel | input | 3 | Operation class and direction |
| cnt_mode | input | 2 | Count source select |
| cnt_reg | input | 32 | Register-sourced count, used modulo 64 |
| imm_cnt | input | 3 | Immediate count, 0 stands for 8 |
| x_in | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Shifted value, upper bits passed through |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The assertions relate each output strobe to the request one cycle earlier. They therefore assume that request fields hold known values whenever `in_valid` is high. They also assume that a result is only consumed in the cycle `out_valid` is high. The stimulus drives every request field to a defined value before raising `in_valid`. It drops `in_valid` between bursts so that the strobe-follow property sees both polarities. It sweeps every byte operand, every operation, both X values and counts around the size boundaries. It covers all three count sources, including register counts above 63 and the immediate code for eight.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int SHF_DW    = 32;
  localparam int SHF_CNT_W = 6;
  localparam int SHF_MAXC  = 1 << SHF_CNT_W;

  typedef enum logic [1:0] {K_ARITH = 2'd0, K_LOGIC = 2'd1, K_ROT = 2'd2, K_ROTX = 2'd3} shf_kind_e;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_L = 2'd2, SZ_L2 = 2'd3} shf_size_e;
  typedef enum logic [1:0] {CM_REG = 2'd0, CM_IMM = 2'd1, CM_ONE = 2'd2, CM_ONE2 = 2'd3} shf_cmode_e;

  typedef struct packed {
    logic [SHF_DW-1:0] v;
    logic              c;
    logic              x;
    logic              vf;
  } shf_state_t;

  function automatic int size_msb(logic [1:0] sz);
    case (sz)
      2'd0:    return 7;
      2'd1:    return 15;
      default: return SHF_DW - 1;
    endcase
  endfunction

  function automatic logic [SHF_DW-1:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return SHF_DW'(32'h0000_00FF);
      2'd1:    return SHF_DW'(32'h0000_FFFF);
      default: return {SHF_DW{1'b1}};
    endcase
  endfunction

  // One single-place step of any of the eight operations.
  function automatic shf_state_t shf_step(shf_state_t s, logic [2:0] op, int msb_i,
                                          logic [SHF_DW-1:0] mask);
    shf_state_t        r;
    shf_kind_e         k;
    logic              oldm;
    logic              outb;
    logic              fill;
    logic [SHF_DW-1:0] nv;
    r    = s;
    k    = shf_kind_e'(op[2:1]);
    oldm = s.v[msb_i];
    if (op[0]) begin
      outb = oldm;
      nv   = (s.v << 1) & mask;
      case (k)
        K_ROT:   fill = outb;
        K_ROTX:  fill = s.x;
        default: fill = 1'b0;
      endcase
      nv[0] = fill;
      if (k == K_ARITH && nv[msb_i] != oldm) r.vf = 1'b1;
    end else begin
      outb = s.v[0];
      nv   = s.v >> 1;
      case (k)
        K_ARITH: fill = oldm;
        K_ROT:   fill = outb;
        K_ROTX:  fill = s.x;
        default: fill = 1'b0;
      endcase
      nv[msb_i] = fill;
    end
    r.c = outb;
    if (k != K_ROT) r.x = outb;
    r.v = nv;
    return r;
  endfunction
endpackage

// File: rtl/shf_count.sv
module shf_count
  import shf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           cnt_mode,
  input  logic [SHF_DW-1:0]    cnt_reg,
  input  logic [2:0]           imm_cnt,
  output logic [SHF_CNT_W-1:0] eff_cnt
);
  always_comb begin
    case (shf_cmode_e'(cnt_mode))
      CM_REG:  eff_cnt = cnt_reg[SHF_CNT_W-1:0];
      CM_IMM:  eff_cnt = (imm_cnt == 3'd0) ? SHF_CNT_W'(8) : SHF_CNT_W'(imm_cnt);
      default: eff_cnt = SHF_CNT_W'(1);
    endcase
  end

  // R3: immediate counts always land in 1..8
  p_imm_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_mode == 2'd1) |-> (eff_cnt != '0 && eff_cnt <= SHF_CNT_W'(8)));
  // R3: memory form always shifts by exactly one
  p_one_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_mode[1]) |-> (eff_cnt == SHF_CNT_W'(1)));
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
(
  input  logic [SHF_DW-1:0]    opnd,
  input  logic [1:0]           size_sel,
  input  logic [2:0]           op_sel,
  input  logic [SHF_CNT_W-1:0] cnt,
  input  logic                 x_in,
  output logic [SHF_DW-1:0]    val_sized,
  output logic                 c_o,
  output logic                 x_o,
  output logic                 v_o
);
  logic [SHF_DW-1:0] mask;
  int                msb_i;
  shf_state_t        st;

  always_comb begin
    mask  = size_mask(size_sel);
    msb_i = size_msb(size_sel);
    st.v  = opnd & mask;
    st.x  = x_in;
    st.c  = (shf_kind_e'(op_sel[2:1]) == K_ROTX) ? x_in : 1'b0;
    st.vf = 1'b0;
    for (int i = 0; i < SHF_MAXC; i++) begin
      if (i < int'(cnt)) st = shf_step(st, op_sel, msb_i, mask);
    end
    val_sized = st.v;
    c_o       = st.c;
    x_o       = st.x;
    v_o       = st.vf;
  end
endmodule

// File: rtl/shf_flags.sv
module shf_flags
  import shf_pkg::*;
(
  input  logic [SHF_DW-1:0] opnd,
  input  logic [1:0]        size_sel,
  input  logic [SHF_DW-1:0] val_sized,
  output logic [SHF_DW-1:0] merged,
  output logic              n_o,
  output logic              z_o
);
  logic [SHF_DW-1:0] mask;
  always_comb begin
    mask   = size_mask(size_sel);
    merged = (opnd & ~mask) | (val_sized & mask);
    n_o    = val_sized[size_msb(size_sel)];
    z_o    = ((val_sized & mask) == '0);
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] opnd,
  input  logic [1:0]  size_sel,
  input  logic [2:0]  op_sel,
  input  logic [1:0]  cnt_mode,
  input  logic [31:0] cnt_reg,
  input  logic [2:0]  imm_cnt,
  input  logic        x_in,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_x,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_v,
  output logic        flag_c
);
  logic [SHF_CNT_W-1:0] eff_cnt;
  logic [SHF_DW-1:0]    val_sized;
  logic [SHF_DW-1:0]    merged;
  logic                 c_w, x_w, v_w, n_w, z_w;

  shf_count u_count (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cnt_mode(cnt_mode),
    .cnt_reg(cnt_reg), .imm_cnt(imm_cnt), .eff_cnt(eff_cnt)
  );

  shf_core u_core (
    .opnd(opnd), .size_sel(size_sel), .op_sel(op_sel), .cnt(eff_cnt), .x_in(x_in),
    .val_sized(val_sized), .c_o(c_w), .x_o(x_w), .v_o(v_w)
  );

  shf_flags u_flags (
    .opnd(opnd), .size_sel(size_sel), .val_sized(val_sized),
    .merged(merged), .n_o(n_w), .z_o(z_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_x    <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= merged;
        flag_x <= x_w;
        flag_n <= n_w;
        flag_z <= z_w;
        flag_v <= v_w;
        flag_c <= c_w;
      end
    end
  end

  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_rot_x_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[2:1] == 2'd2) |=> (flag_x == $past(x_in)));
  p_v_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[2:1] != 2'd0) |=> !flag_v);
  p_zero_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_cnt == '0 && op_sel[2:1] != 2'd3) |=> (!flag_c && flag_x == $past(x_in)));
  p_zero_cnt_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_cnt == '0) |=> (result == $past(opnd)));
  p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel == 2'd0) |=> (result[31:8] == $past(opnd[31:8])));
endmodule

// File: tb/test_shf_unit.sv
module test_shf_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] opnd = '0;
  logic [1:0]  size_sel = '0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  cnt_mode = '0;
  logic [31:0] cnt_reg = '0;
  logic [2:0]  imm_cnt = '0;
  logic        x_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_x, flag_n, flag_z, flag_v, flag_c;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  shf_unit i_shf_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd(opnd), .size_sel(size_sel),
    .op_sel(op_sel), .cnt_mode(cnt_mode), .cnt_reg(cnt_reg), .imm_cnt(imm_cnt), .x_in(x_in),
    .out_valid(out_valid), .result(result), .flag_x(flag_x), .flag_n(flag_n),
    .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h (op=%0d size=%0d opnd=%h cnt_mode=%0d x=%0b)",
               tag, act, exp, op_sel, size_sel, opnd, cnt_mode, x_in);
    end
  endtask

  // Independent reference: closed-form per operation.
  task automatic ref_model(input int w, input logic [2:0] op, input int n,
                           input logic [31:0] a, input logic xi,
                           output logic [31:0] r, output logic c, output logic x,
                           output logic v);
    logic [32:0] e, er;
    logic sgn;
    int k;
    r = '0; c = 1'b0; x = xi; v = 1'b0;
    sgn = a[w-1];
    if (n == 0) begin
      r = a;
      c = (op[2:1] == 2'd3) ? xi : 1'b0;
      return;
    end
    case (op[2:1])
      2'd0, 2'd1: begin
        if (op[0]) begin
          for (int j = 0; j < w; j++) if (j - n >= 0) r[j] = a[j - n];
          c = (n <= w) ? a[w - n] : 1'b0;
          if (op[2:1] == 2'd0) begin
            if (n >= w) v = (a != 0);
            else for (int j = w - 1 - n; j < w; j++) if (a[j] != sgn) v = 1'b1;
          end
        end else begin
          for (int j = 0; j < w; j++)
            r[j] = (j + n < w) ? a[j + n] : ((op[2:1] == 2'd0) ? sgn : 1'b0);
          if (n <= w) c = a[n - 1];
          else c = (op[2:1] == 2'd0) ? sgn : 1'b0;
        end
        x = c;
      end
      2'd2: begin
        k = n % w;
        for (int j = 0; j < w; j++) begin
          if (op[0]) r[(j + k) % w] = a[j];
          else       r[j] = a[(j + k) % w];
        end
        c = op[0] ? r[0] : r[w-1];
      end
      default: begin
        e = '0; er = '0;
        for (int j = 0; j < w; j++) e[j] = a[j];
        e[w] = xi;
        k = n % (w + 1);
        for (int j = 0; j <= w; j++) begin
          if (op[0]) er[(j + k) % (w + 1)] = e[j];
          else       er[j] = e[(j + k) % (w + 1)];
        end
        for (int j = 0; j < w; j++) r[j] = er[j];
        x = er[w];
        c = er[w];
      end
    endcase
  endtask

  task automatic run_one(input logic [1:0] sz, input logic [2:0] op, input logic [1:0] cm,
                         input logic [31:0] creg, input logic [2:0] ci,
                         input logic [31:0] a, input logic xi, input string ctag);
    int w, n;
    logic [31:0] m, er;
    logic ec, ex, ev;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    if (cm == 2'd0)      n = int'(creg % 64);
    else if (cm == 2'd1) n = (ci == 3'd0) ? 8 : int'(ci);
    else                 n = 1;
    ref_model(w, op, n, a & m, xi, er, ec, ex, ev);
    @(negedge clk);
    in_valid = 1'b1; size_sel = sz; op_sel = op; cnt_mode = cm; cnt_reg = creg;
    imm_cnt = ci; opnd = a; x_in = xi;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 out_valid", {31'd0, out_valid}, 32'd1);
    chk(n == 0 ? "R7 zero-count value" : ctag, result & m, er & m);
    chk("R2 upper bits", result & ~m, a & ~m);
    chk(n == 0 ? "R7 zero-count C" : "R4 carry", {31'd0, flag_c}, {31'd0, ec});
    chk(n == 0 ? "R7 zero-count X" : "R4 extend", {31'd0, flag_x}, {31'd0, ex});
    chk("R5 overflow", {31'd0, flag_v}, {31'd0, ev});
    chk("R6 negative", {31'd0, flag_n}, {31'd0, er[w-1]});
    chk("R6 zero", {31'd0, flag_z}, {31'd0, ((er & m) == 0)});
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stim
    int cnts_b [7] = '{0, 1, 2, 7, 8, 9, 63};
    int cnts_w [5] = '{0, 3, 15, 16, 17};
    int cnts_l [6] = '{0, 1, 5, 31, 32, 33};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R8 reset result", result, 32'd0);
    chk("R8 reset flags", {27'd0, flag_x, flag_n, flag_z, flag_v, flag_c}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle valid", {31'd0, out_valid}, 32'd0);

    // R1 byte sweep: every operand, every operation, both X values
    for (int b = 0; b < 256; b++)
      for (int op = 0; op < 8; op++)
        for (int ci = 0; ci < 7; ci++)
          for (int xi = 0; xi < 2; xi++)
            run_one(2'd0, 3'(op), 2'd0, 32'(cnts_b[ci]), 3'd0,
                    32'hA5C3_5E00 | 32'(b), 1'(xi), "R1 byte result");

    // R1 word sample
    for (int k = 0; k < 128; k++)
      for (int op = 0; op < 8; op++)
        for (int ci = 0; ci < 5; ci++)
          run_one(2'd1, 3'(op), 2'd0, 32'(cnts_w[ci]), 3'd0,
                  ((32'(k) * 32'd40503) ^ (32'(k) << 9)) | 32'h7E00_0000, 1'(k & 1),
                  "R1 word result");

    // R1 longword sample, size code 3 on odd entries
    for (int k = 0; k < 64; k++)
      for (int op = 0; op < 8; op++)
        for (int ci = 0; ci < 6; ci++)
          run_one((k & 1) ? 2'd3 : 2'd2, 3'(op), 2'd0, 32'(cnts_l[ci]), 3'd0,
                  (32'(k) * 32'h9E37_79B9) ^ 32'h8000_0001, 1'(k >> 1), "R1 long result");

    // R3 count sources: register modulo 64, immediate 0..7, single place
    for (int op = 0; op < 8; op++) begin
      run_one(2'd1, 3'(op), 2'd0, 32'd70, 3'd0, 32'h0000_C3A5, 1'b1, "R3 reg mod 64");
      run_one(2'd1, 3'(op), 2'd0, 32'hFFFF_FF40, 3'd0, 32'h0000_8001, 1'b0, "R3 reg mod 64 zero");
      for (int ci = 0; ci < 8; ci++)
        run_one(2'd0, 3'(op), 2'd1, 32'd0, 3'(ci), 32'h0000_00EB, 1'b1, "R3 immediate");
      run_one(2'd1, 3'(op), 2'd2, 32'd5, 3'd3, 32'h0000_7E81, 1'b0, "R3 single place");
      run_one(2'd2, 3'(op), 2'd3, 32'd9, 3'd6, 32'h8000_0003, 1'b1, "R3 single place");
    end

    // directed R5 case: 01111110 arithmetic left by one sets V, logical does not
    run_one(2'd0, 3'b001, 2'd2, 32'd0, 3'd0, 32'h0000_007E, 1'b0, "R5 asl sign change");
    run_one(2'd0, 3'b011, 2'd2, 32'd0, 3'd0, 32'h0000_007E, 1'b0, "R5 lsl no overflow");

    @(negedge clk);
    chk("R8 valid drops", {31'd0, out_valid}, 32'd0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule